// File: doc/BRIEF.md
# Strobed Input Handshake Port

This block is one direction of a parallel peripheral port. An external device puts a byte on the data pins and pulses an active-low strobe. The block synchronizes the strobe into the clock domain and captures the pin data while the strobe is low. It then raises a buffer-full flag back to the device. When the strobe returns high, the block marks an interrupt as pending for the CPU.

The CPU side arrives already decoded. A level `rd_act` is high for the duration of a CPU read of this port. A single-bit command write (`cmd_wr`, `cmd_sel`, `cmd_val`) is shared with the other single-bit controls of the port. The interrupt-enable bit sits at the select position given by `INTE_BIT`: 4 for the first port of a pair, 2 for the second. The output `intr` is the pending flag gated by that enable. The captured byte stays on `rd_data` until the next strobe.

Top module: `strb_in_port`

## Requirements
- R1: While the synchronized strobe is low, the latched byte on `rd_data` follows the synchronized pins. While it is high, `rd_data` holds its value, and CPU reads and command writes do not alter it; a second strobe without a read overwrites it.
- R2: `ibf` rises on the falling edge of the synchronized strobe. If `stb_n` is driven low just before clock edge k, `ibf` is still 0 after edge k+1 and is 1 after edge k+2.
- R3: `ibf` is cleared when a CPU read ends, on the first clock edge at which `rd_act` is sampled low after being high. It stays set while `rd_act` is still high.
- R4: A pending interrupt is recorded when the synchronized strobe returns high. `intr` equals pending AND enable: a pending interrupt appears when the enable is later set, and it disappears when the enable is cleared.
- R5: The pending interrupt is cleared at the first clock edge at which `rd_act` is sampled high. If that edge is also the edge at which a strobe rise is detected, the clear wins and `intr` stays 0.
- R6: A command write with `cmd_sel` equal to `INTE_BIT` (default 4, a 3-bit select) loads `cmd_val` into the enable bit. A command write with any other select leaves the enable unchanged.
- R7: After reset, `ibf`, `intr` and `rd_data` are 0, and the enable bit is 0.
- R8: If a strobe fall is detected at the same edge at which a read ends, `ibf` stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_data | input | DATA_W | Data pins from the peripheral |
| stb_n | input | 1 | Asynchronous active-low strobe from the peripheral |
| rd_act | input | 1 | Decoded CPU read of this port, high during the read |
| cmd_wr | input | 1 | Single-bit command write pulse |
| cmd_sel | input | CMD_SEL_W | Bit select of the command |
| cmd_val | input | 1 | Value written by the command |
| rd_data | output | DATA_W | Latched byte presented to the CPU |
| ibf | output | 1 | Buffer-full flag to the peripheral |
| intr | output | 1 | Interrupt request to the CPU |

## Verification
Two pairs of events can fall on the same clock edge. A new strobe fall can coincide with the end of a read, which sets and clears `ibf` at once. A strobe rise can coincide with the start of a read, which sets and clears the pending interrupt at once. The bench counts the two synchronizer stages and places the `rd_act` transition so that both events are sampled at exactly the same edge. It then judges the outcome: `ibf` must remain 1, and `intr` must remain 0 with the enable set.

// File: rtl/strb_in_pkg.sv
package strb_in_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/strb_in_sync.sv
module strb_in_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= din;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/strb_in_edge.sv
module strb_in_edge
  import strb_in_pkg::*;
#(
  parameter logic IDLE = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  lvl,
  output edge_t evt
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= lvl;
  end

  always_comb begin
    evt.rise = lvl & ~prev_q;
    evt.fall = ~lvl & prev_q;
  end
endmodule

// File: rtl/strb_in_ctrl.sv
module strb_in_ctrl
  import strb_in_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CMD_SEL_W = 3,
  parameter int unsigned INTE_BIT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stb_s,
  input  edge_t                stb_evt,
  input  edge_t                rd_evt,
  input  logic [DATA_W-1:0]    data_s,
  input  logic                 cmd_wr,
  input  logic [CMD_SEL_W-1:0] cmd_sel,
  input  logic                 cmd_val,
  output logic [DATA_W-1:0]    latch,
  output logic                 ibf,
  output logic                 pend,
  output logic                 inte
);
  localparam logic [CMD_SEL_W-1:0] SEL_INTE = CMD_SEL_W'(INTE_BIT);

  logic [DATA_W-1:0] latch_q, latch_d;
  logic              latch_en;
  logic              ibf_q, ibf_d;
  logic              pend_q, pend_d;
  logic              inte_q, inte_d;

  always_comb begin
    latch_en = ~stb_s;
    latch_d  = data_s;

    ibf_d = ibf_q;
    if (rd_evt.fall)  ibf_d = 1'b0;
    if (stb_evt.fall) ibf_d = 1'b1;

    pend_d = pend_q;
    if (stb_evt.rise) pend_d = 1'b1;
    if (rd_evt.rise)  pend_d = 1'b0;

    inte_d = inte_q;
    if (cmd_wr && (cmd_sel == SEL_INTE)) inte_d = cmd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      ibf_q   <= 1'b0;
      pend_q  <= 1'b0;
      inte_q  <= 1'b0;
    end else begin
      if (latch_en) latch_q <= latch_d;
      ibf_q  <= ibf_d;
      pend_q <= pend_d;
      inte_q <= inte_d;
    end
  end

  assign latch = latch_q;
  assign ibf   = ibf_q;
  assign pend  = pend_q;
  assign inte  = inte_q;
endmodule

// File: rtl/strb_in_port.sv
module strb_in_port
  import strb_in_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CMD_SEL_W = 3,
  parameter int unsigned INTE_BIT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_W-1:0]    pin_data,
  input  logic                 stb_n,
  input  logic                 rd_act,
  input  logic                 cmd_wr,
  input  logic [CMD_SEL_W-1:0] cmd_sel,
  input  logic                 cmd_val,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 ibf,
  output logic                 intr
);
  logic              stb_s;
  logic [DATA_W-1:0] data_s;
  edge_t             stb_evt;
  edge_t             rd_evt;
  logic              pend;
  logic              inte;

  strb_in_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stb_sync (
    .clk(clk), .rst_n(rst_n), .din(stb_n), .dout(stb_s)
  );

  strb_in_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_data), .dout(data_s)
  );

  strb_in_edge #(.IDLE(1'b1)) u_stb_edge (
    .clk(clk), .rst_n(rst_n), .lvl(stb_s), .evt(stb_evt)
  );

  strb_in_edge #(.IDLE(1'b0)) u_rd_edge (
    .clk(clk), .rst_n(rst_n), .lvl(rd_act), .evt(rd_evt)
  );

  strb_in_ctrl #(.DATA_W(DATA_W), .CMD_SEL_W(CMD_SEL_W), .INTE_BIT(INTE_BIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .stb_s(stb_s), .stb_evt(stb_evt), .rd_evt(rd_evt),
    .data_s(data_s), .cmd_wr(cmd_wr), .cmd_sel(cmd_sel), .cmd_val(cmd_val),
    .latch(rd_data), .ibf(ibf), .pend(pend), .inte(inte)
  );

  assign intr = pend & inte;
endmodule

// File: rtl/strb_in_chk.sv
module strb_in_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stb_s,
  input logic              stb_rise,
  input logic              stb_fall,
  input logic              rd_rise,
  input logic              rd_fall,
  input logic              cmd_wr,
  input logic              inte,
  input logic [DATA_W-1:0] rd_data,
  input logic              ibf,
  input logic              intr
);
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stb_s) |-> $stable(rd_data)); // R1

  AST_IBF_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
    stb_fall |=> ibf); // R2

  AST_IBF_CLR_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && !stb_fall) |=> !ibf); // R3

  AST_INTR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr) |-> ($past(stb_rise) || $past(cmd_wr))); // R4

  AST_INTR_CLR_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise |=> !intr); // R5

  AST_INTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_wr) |-> $stable(inte)); // R6
endmodule

bind strb_in_port strb_in_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stb_s(stb_s),
  .stb_rise(stb_evt.rise), .stb_fall(stb_evt.fall),
  .rd_rise(rd_evt.rise), .rd_fall(rd_evt.fall),
  .cmd_wr(cmd_wr), .inte(inte), .rd_data(rd_data), .ibf(ibf), .intr(intr)
);

// File: tb/sim_strb_in_port.sv
module sim_strb_in_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_data = '0;
  logic       stb_n = 1'b1;
  logic       rd_act = 1'b0;
  logic       cmd_wr = 1'b0;
  logic [2:0] cmd_sel = '0;
  logic       cmd_val = 1'b0;
  logic [7:0] rd_data;
  logic       ibf;
  logic       intr;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  strb_in_port u0 (
    .clk(clk), .rst_n(rst_n), .pin_data(pin_data), .stb_n(stb_n), .rd_act(rd_act),
    .cmd_wr(cmd_wr), .cmd_sel(cmd_sel), .cmd_val(cmd_val),
    .rd_data(rd_data), .ibf(ibf), .intr(intr)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic strobe(input logic [7:0] b);
    @(negedge clk);
    pin_data = b;
    stb_n = 1'b0;
    cycles(4);
    stb_n = 1'b1;
    cycles(4);
  endtask

  task automatic cpu_read();
    @(negedge clk);
    rd_act = 1'b1;
    cycles(2);
    rd_act = 1'b0;
    cycles(2);
  endtask

  task automatic bit_cmd(input logic [2:0] sel, input logic val);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_sel = sel; cmd_val = val;
    @(negedge clk);
    cmd_wr = 1'b0;
    cycles(1);
  endtask

  task automatic t_reset();
    chk("R7 ibf", {7'd0, ibf}, 8'd0);
    chk("R7 intr", {7'd0, intr}, 8'd0);
    chk("R7 rd_data", rd_data, 8'h00);
  endtask

  task automatic t_latency();
    @(negedge clk);
    pin_data = 8'h3C;
    stb_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 chk("R2 ibf before k+2", {7'd0, ibf}, 8'd0);
    @(posedge clk);
    #1 chk("R2 ibf at k+2", {7'd0, ibf}, 8'd1);
    cycles(3);
    stb_n = 1'b1;
    cycles(4);
    // R4 / R7: enable still 0 after reset, so no request
    chk("R7 enable off, intr", {7'd0, intr}, 8'd0);
    chk("R1 captured", rd_data, 8'h3C);
  endtask

  task automatic t_capture();
    cpu_read();
    strobe(8'hA5);
    chk("R1 captured A5", rd_data, 8'hA5);
    pin_data = 8'h5A;
    cycles(4);
    chk("R1 pins change after strobe", rd_data, 8'hA5);
    bit_cmd(3'd4, 1'b0);
    cpu_read();
    chk("R1 held over read", rd_data, 8'hA5);
    strobe(8'h11);
    strobe(8'h22);
    chk("R1 overwrite without read", rd_data, 8'h22);
  endtask

  task automatic t_gate();
    chk("R4 pending masked", {7'd0, intr}, 8'd0);
    bit_cmd(3'd4, 1'b1);
    chk("R4 pending revealed", {7'd0, intr}, 8'd1);
    bit_cmd(3'd4, 1'b0);
    chk("R4 masked again", {7'd0, intr}, 8'd0);
    bit_cmd(3'd4, 1'b1);
    chk("R4 revealed again", {7'd0, intr}, 8'd1);
  endtask

  task automatic t_read();
    @(negedge clk);
    rd_act = 1'b1;
    @(posedge clk);
    #1 chk("R5 intr cleared at read start", {7'd0, intr}, 8'd0);
    chk("R3 ibf kept during read", {7'd0, ibf}, 8'd1);
    cycles(2);
    chk("R3 ibf still set while rd_act high", {7'd0, ibf}, 8'd1);
    rd_act = 1'b0;
    @(posedge clk);
    #1 chk("R3 ibf cleared at read end", {7'd0, ibf}, 8'd0);
    cycles(1);
  endtask

  task automatic t_sel();
    bit_cmd(3'd2, 1'b0);
    strobe(8'h77);
    chk("R6 other select ignored, intr", {7'd0, intr}, 8'd1);
    bit_cmd(3'd4, 1'b0);
    chk("R6 enable cleared", {7'd0, intr}, 8'd0);
    bit_cmd(3'd3, 1'b1);
    chk("R6 select 3 ignored", {7'd0, intr}, 8'd0);
    bit_cmd(3'd4, 1'b1);
    cpu_read();
  endtask

  task automatic t_coll_ibf();
    strobe(8'h99);
    @(negedge clk);
    rd_act = 1'b1;
    cycles(2);
    stb_n = 1'b0;
    pin_data = 8'hC3;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rd_act = 1'b0;
    cycles(3);
    chk("R8 ibf kept on collision", {7'd0, ibf}, 8'd1);
    stb_n = 1'b1;
    cycles(4);
    chk("R8 new byte latched", rd_data, 8'hC3);
  endtask

  task automatic t_coll_intr();
    cpu_read();
    @(negedge clk);
    stb_n = 1'b0;
    pin_data = 8'h0F;
    cycles(4);
    stb_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rd_act = 1'b1;
    cycles(2);
    chk("R5 read wins over strobe rise", {7'd0, intr}, 8'd0);
    rd_act = 1'b0;
    cycles(2);
    chk("R5 intr stays low after read", {7'd0, intr}, 8'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_latency();
    t_capture();
    t_gate();
    t_read();
    t_sel();
    t_coll_ibf();
    t_coll_intr();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule